// File: doc/BRIEF.md
# Rank and DRAM Coordinate Mapper

This block takes a channel-relative memory address and resolves it into the DRAM coordinates that the address reaches: a rank address and then row, column, bank and bank group. The rank part of the resolution works in three steps. The block first finds which of up to four rank-range entries covers the address. It then removes the rank-interleave ways from the address and uses the selected way to pick an entry that supplies a channel rank and an offset. The channel rank is finally split into a DIMM number and a rank within that DIMM.

The DRAM part gathers row and column bits from fixed bit-position lists. There is one set of lists for closed-page operation, one for open-page operation, and a separate column list for open-page operation with fine-grain banks. Bank and bank group can optionally be XOR-hashed with higher address bits.

A request is accepted with a valid/ready handshake and passes through a three-state machine. The states are IDLE, MATCH and MAP, and the transitions are:
- IDLE to MATCH when a request is accepted.
- MATCH to MAP when a range entry matches.
- MATCH to IDLE when no entry matches; the block reports an error here.
- MAP to IDLE unconditionally; the coordinates are reported here.

The range and way tables are quasi-static inputs. The per-request configuration (row bit count, column bit count, page mode, fine-grain mode and hashing) is captured when the request is accepted.

Top module: `rank_coord_mapper`

## Requirements
- R1: `in_ready` is high only in IDLE. A request accepted at clock edge N gives exactly one cycle of `out_valid`: after edge N+1 when it misses, or after edge N+2 when it hits. `in_ready` is low in the cycles between acceptance and that result.
- R2: Range entry r is `range_tbl[r*14 +: 14]`. Bit 13 is the valid flag, bits 12:11 are the log2 of the way count, and bits 10:0 are the limit field. The limit is (field << 29) with the low 29 bits set. The lower bound is the limit of the previous entry, valid or not, and is 0 for entry 0. Both bounds are inclusive. Among the valid entries that match, the lowest index wins.
- R3: When no valid entry matches, `out_err` is raised together with `out_valid`, and the rank address, row, column, bank, bank group, DIMM and rank outputs are all zero.
- R4: The shift is 6 in closed-page mode and 13 in open-page mode. The way is (addr >> shift) mod ways. The way word for range r is `way_tbl[(r*8+way)*18 +: 18]`: bits 17:14 hold the channel rank and bits 13:0 hold the offset field. The rank address is computed in three steps, modulo 2^ADDR_W: take ((addr >> shift) / ways) << shift, OR in the low shift bits of addr, and subtract (offset field << 26).
- R5: `out_dimm` is channel rank bits 3:2, and `out_rank` is channel rank bits 1:0.
- R6: In closed-page mode, row bit i takes rank-address bit i of the list 15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33. Column bit i takes bit i of the list 3,4,5,14,19,23,24,25,26,27. Column bit 10 is always 1.
- R7: In open-page mode, row bit i takes bit i of the list 14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33. Column bit i is rank-address bit i+3. Column bit 10 is 0.
- R8: In open-page mode with fine-grain banks, column bits come from the list 3,4,5,7,8,9,10,11,12,13.
- R9: The bank is {a19,a18} in open-page mode and {a9,a8} in closed-page mode. The bank group is {a17,a13} in open-page mode, {a17,a6} in open-page mode with fine grain, and {a7,a6} in closed-page mode. With hashing on, the bank is XORed with {a23,a22} (open-page) or {a28,a22} (closed-page), and the bank group is XORed with {a21,a20}.
- R10: Row bits at or above `cfg_row_bits` are 0, and column bits at or above `cfg_col_bits` are 0 except for the forced bit 10. The configuration is taken from the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| in_chan_addr | input | ADDR_W | Channel address to resolve |
| cfg_row_bits | input | 5 | Number of row bits (up to 17) |
| cfg_col_bits | input | 4 | Number of column bits (up to 10) |
| cfg_close_page | input | 1 | Closed-page mapping selected |
| cfg_fine_grain | input | 1 | Fine-grain bank mapping selected |
| cfg_xor_en | input | 1 | Bank and bank group hashing enabled |
| range_tbl | input | NUM_RANGES*14 | Rank range entries |
| way_tbl | input | NUM_RANGES*8*18 | Per-way rank/offset words |
| out_valid | output | 1 | Result pulse |
| out_err | output | 1 | No range entry matched |
| out_rank_addr | output | ADDR_W | Rank address |
| out_dimm | output | 2 | DIMM number |
| out_rank | output | 2 | Rank within DIMM |
| out_row | output | 17 | DRAM row |
| out_col | output | 11 | DRAM column |
| out_bank | output | 2 | Bank address |
| out_bg | output | 2 | Bank group |

## Verification
Several properties are checked by assertions on every cycle:
- the result is a single-cycle pulse;
- `in_ready` drops after an acceptance;
- an error result carries cleared coordinates;
- column bit 10 follows the page mode;
- the row never has bits set above the configured width.

Other behaviours can be shown only by the bench's scenarios, which compare each result against an independent model:
- which range entry wins at the inclusive boundaries and across an invalid entry;
- the way selection and offset subtraction;
- the exact bit scatter for each page mode;
- the XOR hashing;
- the two result latencies.

// File: rtl/rcm_pkg.sv
`timescale 1ns/1ps
package rcm_pkg;
    // Range entry layout
    localparam int RNG_W     = 14;
    localparam int VALID_BIT = 13;
    localparam int WAYS_LO   = 11;
    localparam int LIM_W     = 11;
    localparam int LIM_LSB   = 29;
    // Way entry layout
    localparam int WAY_W     = 18;
    localparam int OFF_W     = 14;
    localparam int OFF_LSB   = 26;
    localparam int MAX_WAYS  = 8;
    // Coordinate geometry
    localparam int ROW_MAX   = 17;
    localparam int COL_MAX   = 10;
    localparam int POS_LO    = 3;
    localparam int POS_HI    = 33;
    localparam int SH_CLOSE  = 6;
    localparam int SH_OPEN   = 13;

    typedef enum logic [1:0] {ST_IDLE, ST_MATCH, ST_MAP} map_state_t;

    function automatic int row_pos(input logic close_pg, input int idx);
        if (close_pg) begin
            if (idx < 4)       return 15 + idx;
            else if (idx < 7)  return 16 + idx;
            else if (idx == 7) return 28;
            else if (idx < 12) return idx + 2;
            else               return idx + 17;
        end else begin
            if (idx < 3)       return 14 + idx;
            else if (idx == 3) return 20;
            else if (idx == 4) return 28;
            else if (idx < 12) return idx + 16;
            else               return idx + 17;
        end
    endfunction

    function automatic int col_pos(input logic close_pg, input logic fine, input int idx);
        if (close_pg) begin
            if (idx < 3)       return idx + 3;
            else if (idx == 3) return 14;
            else if (idx == 4) return 19;
            else               return idx + 18;
        end else if (fine) begin
            return (idx < 3) ? idx + 3 : idx + 4;
        end else begin
            return idx + 3;
        end
    endfunction
endpackage

// File: rtl/rank_range_match.sv
`timescale 1ns/1ps
module rank_range_match
    import rcm_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int NUM_RANGES = 4
) (
    input  logic [ADDR_W-1:0]                     addr,
    input  logic                                  close_pg,
    input  logic [NUM_RANGES*RNG_W-1:0]           range_tbl,
    input  logic [NUM_RANGES*MAX_WAYS*WAY_W-1:0]  way_tbl,
    output logic                                  hit,
    output logic [ADDR_W-1:0]                     rank_addr,
    output logic [3:0]                            chan_rank
);
    localparam int SEL_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1;

    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] lim, prev;
    logic [RNG_W-1:0]  ent;

    // Priority search over the range entries, lowest index first
    always_comb begin
        hit  = 1'b0;
        sel  = '0;
        prev = '0;
        lim  = '0;
        ent  = '0;
        for (int r = 0; r < NUM_RANGES; r++) begin
            ent = range_tbl[r*RNG_W +: RNG_W];
            lim = (ADDR_W'(ent[LIM_W-1:0]) << LIM_LSB) | ADDR_W'({LIM_LSB{1'b1}});
            if (!hit && ent[VALID_BIT] && addr >= prev && addr <= lim) begin
                hit = 1'b1;
                sel = SEL_W'(r);
            end
            prev = lim;
        end
    end

    logic [1:0]        ways_log;
    logic [2:0]        way;
    logic [3:0]        sh;
    logic [ADDR_W-1:0] q, base;
    logic [WAY_W-1:0]  pw;

    // Way removal and offset subtraction
    always_comb begin
        ways_log  = range_tbl[int'(sel)*RNG_W + WAYS_LO +: 2];
        sh        = close_pg ? 4'(SH_CLOSE) : 4'(SH_OPEN);
        q         = addr >> sh;
        way       = q[2:0] & ~(3'b111 << ways_log);
        pw        = way_tbl[(int'(sel)*MAX_WAYS + int'(way))*WAY_W +: WAY_W];
        base      = ((q >> ways_log) << sh) | (addr & ~({ADDR_W{1'b1}} << sh));
        rank_addr = base - (ADDR_W'(pw[OFF_W-1:0]) << OFF_LSB);
        chan_rank = pw[WAY_W-1 -: 4];
    end
endmodule

// File: rtl/dram_coord_gather.sv
`timescale 1ns/1ps
module dram_coord_gather
    import rcm_pkg::*;
#(
    parameter int RB_W = 5,
    parameter int CB_W = 4
) (
    input  logic [POS_HI:POS_LO] ra,
    input  logic                 close_pg,
    input  logic                 fine_grain,
    input  logic                 xor_en,
    input  logic [RB_W-1:0]      row_bits,
    input  logic [CB_W-1:0]      col_bits,
    output logic [ROW_MAX-1:0]   row,
    output logic [COL_MAX:0]     col,
    output logic [1:0]           bank,
    output logic [1:0]           bg
);
    logic [1:0] b_raw, b_hash, g_raw, g_hash;

    always_comb begin
        row = '0;
        for (int i = 0; i < ROW_MAX; i++) begin
            if (i < int'(row_bits)) row[i] = ra[row_pos(close_pg, i)];
        end
        col = '0;
        for (int i = 0; i < COL_MAX; i++) begin
            if (i < int'(col_bits)) col[i] = ra[col_pos(close_pg, fine_grain, i)];
        end
        col[COL_MAX] = close_pg;
    end

    always_comb begin
        b_raw  = close_pg ? {ra[9], ra[8]}   : {ra[19], ra[18]};
        b_hash = close_pg ? {ra[28], ra[22]} : {ra[23], ra[22]};
        g_raw  = close_pg ? {ra[7], ra[6]}   : {ra[17], (fine_grain ? ra[6] : ra[13])};
        g_hash = {ra[21], ra[20]};
        bank   = b_raw ^ (xor_en ? b_hash : 2'b00);
        bg     = g_raw ^ (xor_en ? g_hash : 2'b00);
    end
endmodule

// File: rtl/rank_coord_mapper.sv
`timescale 1ns/1ps
module rank_coord_mapper
    import rcm_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int NUM_RANGES = 4,
    localparam int RB_W      = $clog2(ROW_MAX + 1),
    localparam int CB_W      = $clog2(COL_MAX + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    output logic                                  in_ready,
    input  logic [ADDR_W-1:0]                     in_chan_addr,
    input  logic [RB_W-1:0]                       cfg_row_bits,
    input  logic [CB_W-1:0]                       cfg_col_bits,
    input  logic                                  cfg_close_page,
    input  logic                                  cfg_fine_grain,
    input  logic                                  cfg_xor_en,
    input  logic [NUM_RANGES*RNG_W-1:0]           range_tbl,
    input  logic [NUM_RANGES*MAX_WAYS*WAY_W-1:0]  way_tbl,
    output logic                                  out_valid,
    output logic                                  out_err,
    output logic [ADDR_W-1:0]                     out_rank_addr,
    output logic [1:0]                            out_dimm,
    output logic [1:0]                            out_rank,
    output logic [ROW_MAX-1:0]                    out_row,
    output logic [COL_MAX:0]                      out_col,
    output logic [1:0]                            out_bank,
    output logic [1:0]                            out_bg
);
    map_state_t state, nxt;

    logic [ADDR_W-1:0] addr_q, ra_q, ra_c;
    logic [RB_W-1:0]   rb_q;
    logic [CB_W-1:0]   cb_q;
    logic              close_q, fine_q, xor_q;
    logic [3:0]        crank_q, crank_c;
    logic              hit_c, accept;
    logic [ROW_MAX-1:0] row_c;
    logic [COL_MAX:0]   col_c;
    logic [1:0]         bank_c, bg_c;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;

    rank_range_match #(.ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES)) u_match (
        .addr(addr_q), .close_pg(close_q), .range_tbl(range_tbl), .way_tbl(way_tbl),
        .hit(hit_c), .rank_addr(ra_c), .chan_rank(crank_c)
    );

    dram_coord_gather #(.RB_W(RB_W), .CB_W(CB_W)) u_gather (
        .ra(ra_q[POS_HI:POS_LO]), .close_pg(close_q), .fine_grain(fine_q), .xor_en(xor_q),
        .row_bits(rb_q), .col_bits(cb_q),
        .row(row_c), .col(col_c), .bank(bank_c), .bg(bg_c)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = accept ? ST_MATCH : ST_IDLE;
            ST_MATCH: nxt = hit_c ? ST_MAP : ST_IDLE;
            ST_MAP:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Data path and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0; ra_q <= '0; rb_q <= '0; cb_q <= '0;
            close_q <= 1'b0; fine_q <= 1'b0; xor_q <= 1'b0; crank_q <= '0;
            out_valid <= 1'b0; out_err <= 1'b0; out_rank_addr <= '0;
            out_dimm <= '0; out_rank <= '0; out_row <= '0; out_col <= '0;
            out_bank <= '0; out_bg <= '0;
        end else begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q  <= in_chan_addr;
                        rb_q    <= cfg_row_bits;
                        cb_q    <= cfg_col_bits;
                        close_q <= cfg_close_page;
                        fine_q  <= cfg_fine_grain;
                        xor_q   <= cfg_xor_en;
                    end
                end
                ST_MATCH: begin
                    if (hit_c) begin
                        ra_q    <= ra_c;
                        crank_q <= crank_c;
                    end else begin
                        out_valid     <= 1'b1;
                        out_err       <= 1'b1;
                        out_rank_addr <= '0;
                        out_dimm      <= '0;
                        out_rank      <= '0;
                        out_row       <= '0;
                        out_col       <= '0;
                        out_bank      <= '0;
                        out_bg        <= '0;
                    end
                end
                ST_MAP: begin
                    out_valid     <= 1'b1;
                    out_rank_addr <= ra_q;
                    out_dimm      <= crank_q[3:2];
                    out_rank      <= crank_q[1:0];
                    out_row       <= row_c;
                    out_col       <= col_c;
                    out_bank      <= bank_c;
                    out_bg        <= bg_c;
                end
                default: ;
            endcase
        end
    end

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r3_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && out_row == '0 && out_col == '0 && out_rank_addr == '0));

    a_r6_col10_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && close_q) |-> out_col[COL_MAX]);

    a_r7_col10_open: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && !close_q) |-> !out_col[COL_MAX]);

    a_r10_row_masked: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_row >> rb_q) == '0));
endmodule

// File: tb/rank_coord_mapper_tb.sv
`timescale 1ns/1ps
module rank_coord_mapper_tb;
    import rcm_pkg::*;

    localparam int AW = 40;
    localparam int NR = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, in_valid, in_ready;
    logic [AW-1:0] in_chan_addr;
    logic [4:0] cfg_row_bits;
    logic [3:0] cfg_col_bits;
    logic cfg_close_page, cfg_fine_grain, cfg_xor_en;
    logic [NR*RNG_W-1:0] range_tbl;
    logic [NR*MAX_WAYS*WAY_W-1:0] way_tbl;
    logic out_valid, out_err;
    logic [AW-1:0] out_rank_addr;
    logic [1:0] out_dimm, out_rank, out_bank, out_bg;
    logic [16:0] out_row;
    logic [10:0] out_col;

    logic [RNG_W-1:0] rng [NR];
    logic [WAY_W-1:0] wy  [NR][MAX_WAYS];

    for (genvar r = 0; r < NR; r++) begin : g_rng
        assign range_tbl[r*RNG_W +: RNG_W] = rng[r];
        for (genvar w = 0; w < MAX_WAYS; w++) begin : g_way
            assign way_tbl[(r*MAX_WAYS+w)*WAY_W +: WAY_W] = wy[r][w];
        end
    end

    rank_coord_mapper #(.ADDR_W(AW), .NUM_RANGES(NR)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_chan_addr(in_chan_addr), .cfg_row_bits(cfg_row_bits), .cfg_col_bits(cfg_col_bits),
        .cfg_close_page(cfg_close_page), .cfg_fine_grain(cfg_fine_grain), .cfg_xor_en(cfg_xor_en),
        .range_tbl(range_tbl), .way_tbl(way_tbl),
        .out_valid(out_valid), .out_err(out_err), .out_rank_addr(out_rank_addr),
        .out_dimm(out_dimm), .out_rank(out_rank), .out_row(out_row), .out_col(out_col),
        .out_bank(out_bank), .out_bg(out_bg)
    );

    typedef struct {
        bit        err;
        bit [39:0] ra;
        bit [1:0]  dimm, rk, bank, bg;
        bit [16:0] row;
        bit [10:0] col;
        int        mode;
        int        rb;
        int        due;
    } exp_t;

    exp_t sb_q[$];
    exp_t mon_e;
    int nchecks = 0;
    int nfail   = 0;
    int cyc     = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input bit [39:0] a, input bit cp, input bit fg, input bit xr,
                                   input int rb, input int cb);
        exp_t e;
        bit [39:0] prev, lim, q, ra, ways;
        int sel, w, sh;
        bit [17:0] pw;
        int crow [17] = '{15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33};
        int orow [17] = '{14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33};
        int ccol [10] = '{3,4,5,14,19,23,24,25,26,27};
        int ocol [10] = '{3,4,5,6,7,8,9,10,11,12};
        int fcol [10] = '{3,4,5,7,8,9,10,11,12,13};
        bit [1:0] b, g;
        e = '{default: 0};
        e.rb = rb;
        e.mode = cp ? 6 : (fg ? 8 : 7);
        prev = 0;
        sel = -1;
        for (int r = 0; r < NR; r++) begin
            lim = ({29'b0, rng[r][10:0]} << 29) | 40'h1FFF_FFFF;
            if (sel < 0 && rng[r][13] && a >= prev && a <= lim) sel = r;
            prev = lim;
        end
        if (sel < 0) begin
            e.err = 1'b1;
            return e;
        end
        sh   = cp ? 6 : 13;
        ways = 40'd1 << rng[sel][12:11];
        q    = a >> sh;
        w    = int'(q % ways);
        ra   = ((q / ways) << sh) | (a & ((40'd1 << sh) - 40'd1));
        pw   = wy[sel][w];
        ra   = ra - ({26'b0, pw[13:0]} << 26);
        e.ra = ra;
        e.dimm = pw[17:16];
        e.rk   = pw[15:14];
        for (int i = 0; i < rb && i < 17; i++) e.row[i] = ra[cp ? crow[i] : orow[i]];
        for (int i = 0; i < cb && i < 10; i++) e.col[i] = ra[cp ? ccol[i] : (fg ? fcol[i] : ocol[i])];
        if (cp) e.col[10] = 1'b1;
        if (cp) begin
            b = {ra[9], ra[8]};
            g = {ra[7], ra[6]};
            if (xr) begin b ^= {ra[28], ra[22]}; g ^= {ra[21], ra[20]}; end
        end else begin
            b = {ra[19], ra[18]};
            g = {ra[17], fg ? ra[6] : ra[13]};
            if (xr) begin b ^= {ra[23], ra[22]}; g ^= {ra[21], ra[20]}; end
        end
        e.bank = b;
        e.bg = g;
        return e;
    endfunction

    task automatic send(input bit [39:0] a, input bit cp, input bit fg, input bit xr,
                        input int rb, input int cb);
        exp_t e;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_chan_addr   = a;
        cfg_close_page = cp;
        cfg_fine_grain = fg;
        cfg_xor_en     = xr;
        cfg_row_bits   = 5'(rb);
        cfg_col_bits   = 4'(cb);
        in_valid       = 1'b1;
        e = model(a, cp, fg, xr, rb, cb);
        e.due = cyc + (e.err ? 2 : 3);
        sb_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "ready while busy", 64'(in_ready), 64'd0);
    endtask

    // Monitor: compares each result with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                chk("R1", "unexpected result", 64'd1, 64'd0);
            end else begin
                string mt;
                mon_e = sb_q.pop_front();
                mt = (mon_e.mode == 6) ? "R6" : ((mon_e.mode == 8) ? "R8" : "R7");
                chk("R1", "result cycle", 64'(cyc), 64'(mon_e.due));
                chk(mon_e.err ? "R3" : "R2", "error flag", 64'(out_err), 64'(mon_e.err));
                if (!mon_e.err) begin
                    chk("R4", "rank address", 64'(out_rank_addr), 64'(mon_e.ra));
                    chk("R5", "dimm", 64'(out_dimm), 64'(mon_e.dimm));
                    chk("R5", "rank in dimm", 64'(out_rank), 64'(mon_e.rk));
                    chk(mt, "row", 64'(out_row), 64'(mon_e.row));
                    chk(mt, "column", 64'(out_col), 64'(mon_e.col));
                    chk("R9", "bank", 64'(out_bank), 64'(mon_e.bank));
                    chk("R9", "bank group", 64'(out_bg), 64'(mon_e.bg));
                    chk("R10", "row width", 64'(out_row >> mon_e.rb), 64'd0);
                end else begin
                    chk("R3", "cleared coords",
                        {out_rank_addr[23:0], out_row, out_col, out_bank, out_bg, out_dimm, out_rank},
                        64'd0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchecks++;
        nfail++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        rng[0] = {1'b1, 2'd0, 11'd0};
        rng[1] = {1'b1, 2'd2, 11'd3};
        rng[2] = {1'b0, 2'd1, 11'd5};
        rng[3] = {1'b1, 2'd3, 11'd7};
        for (int r = 0; r < NR; r++)
            for (int w = 0; w < MAX_WAYS; w++)
                wy[r][w] = {4'((r*5 + w*3) % 16), 14'((r*8 + w) % 5)};
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_chan_addr = '0;
        cfg_row_bits = 5'd17;
        cfg_col_bits = 4'd10;
        cfg_close_page = 1'b1;
        cfg_fine_grain = 1'b0;
        cfg_xor_en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "reset in_ready", 64'(in_ready), 64'd1);
        chk("R1", "reset out_valid", 64'(out_valid), 64'd0);
        chk("R3", "reset out_err", 64'(out_err), 64'd0);
        rst_n = 1'b1;

        // R2 range boundaries, priority and invalid entry; R3 misses
        send(40'h00_0000_1000, 1, 0, 0, 17, 10);
        send(40'h00_1FFF_FFFF, 1, 0, 0, 17, 10);
        send(40'h00_2000_0000, 0, 0, 0, 17, 10);
        send(40'h00_9000_0000, 1, 0, 0, 17, 10);
        send(40'h00_BFFF_FFFF, 0, 1, 1, 17, 10);
        send(40'h00_FFFF_FFFF, 1, 0, 1, 17, 10);
        send(40'h01_0000_0000, 0, 0, 0, 17, 10);
        // R10 narrow row and column widths
        send(40'h00_7FFF_FFC0, 1, 0, 0, 12, 8);
        send(40'h00_7FFF_FFC0, 0, 0, 0, 14, 9);

        // R6 R7 R8 R9 across modes and random addresses
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 30; k++) begin
                bit [39:0] a;
                a = {8'((k % 11 == 0) ? 1 : 0), 32'($urandom)};
                send(a, m[0], m[1], m[2], 12 + int'($urandom % 6), 8 + int'($urandom % 3));
            end
        end

        repeat (8) @(negedge clk);
        chk("R1", "outstanding results", 64'(sb_q.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule